// File: doc/BRIEF.md
# Gray-Code Coarse Timestamp Latch

This block gives a group of channels one shared coarse time base and a place to hold a timestamp for each channel. A single 12-bit counter runs in Gray code. It steps once on every edge of the timing clock, and every channel reads it. Each channel has its own capture register. A peak strobe arms the channel. When the channel's stop condition then fires, the register takes the counter value together with that channel's 8-bit fine-time code. The result is a 20-bit stamp.

The stop source is chosen at run time and applies to every channel. In tick mode, an armed channel captures at the next counter step. In external mode, an armed channel waits until the shared external stop input is high on a clock edge. Each armed event is captured exactly once. A synchronous reset puts the counter back at zero and disarms every channel.

Top module: `gray_stamp_latch`

## Requirements
- R1: The coarse counter holds a 12-bit Gray code. It advances on every clock edge while reset is low, and exactly one of its bits changes per step.
- R2: While `rst` is high on a clock edge, the counter is cleared to zero, every channel is disarmed, every `valid_o` bit is low and every stamp is zero. The first edge with `rst` low brings the counter to Gray(1).
- R3: A high `peak_i[c]` on a clock edge arms channel c from the next cycle on.
- R4: With `stop_sel_i` = 0 (tick mode), an armed channel captures on the next clock edge. The value it latches is the counter value after that edge's step, that is Gray(n), where n is the number of edges since reset was released.
- R5: With `stop_sel_i` = 1 (external mode), an armed channel captures on the first edge where `ext_stop_i` is high. The value it latches is the counter value after that edge's step.
- R6: A capture disarms the channel. A peak on an already armed channel, and an external stop seen by an unarmed channel, have no effect. `ext_stop_i` is ignored in tick mode.
- R7: The stamp of channel c is `stamp_o[c*20 +: 20]`. Bits [19:8] hold the Gray coarse value and bits [7:0] hold `fine_i[c*8 +: 8]` as sampled on the capture edge.
- R8: `valid_o[c]` is high for the one cycle after each capture edge. The stamp keeps its value until the next capture or reset.
- R9: The counter wraps from binary 4095 (Gray 0x800) to 0.
- R10: A peak on the same edge as a capture re-arms the channel for a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; the counter steps on each rising edge |
| rst | input | 1 | Synchronous reset, active high |
| peak_i | input | 4 | Per-channel peak strobe, bit c for channel c |
| ext_stop_i | input | 1 | Shared external stop |
| stop_sel_i | input | 1 | Stop source: 0 next counter step, 1 external stop |
| fine_i | input | 32 | Per-channel 8-bit fine code, channel c at [c*8 +: 8] |
| stamp_o | output | 80 | Per-channel 20-bit stamp, channel c at [c*20 +: 20] |
| valid_o | output | 4 | Per-channel one-cycle capture flag |

## Verification
The bench goes after the step in which the latch takes its value. A design that latched the counter value from before the step would produce every coarse field one Gray code too low. It also crosses the 4095-to-0 wrap, where a binary-encoded or badly decoded counter would jump by several bits. Two cases probe the arming logic. A peak while a channel is already armed would produce a duplicate stamp in a design that does not ignore it. A peak on the same edge as a capture would silently lose the next event in a design that clears the channel too eagerly. The bench also switches between stop modes and resets while channels are armed. A leaky arming flag would then produce captures that no peak caused.

// File: rtl/gts_pkg.sv
package gts_pkg;

   // Source of the stop condition that ends an armed channel's wait.
   typedef enum logic {
      STOP_ON_TICK = 1'b0,
      STOP_ON_EXT  = 1'b1
   } stop_src_e;

   // Legal range for the coarse counter width.
   localparam int unsigned GTS_MIN_COARSE = 2;
   localparam int unsigned GTS_MAX_COARSE = 31;

   // Counter implementation variants.
   localparam int unsigned GTS_CNT_SHADOW = 0;   // binary shadow register
   localparam int unsigned GTS_CNT_DECODE = 1;   // Gray register only

endpackage

// File: rtl/gts_gray_counter.sv
module gts_gray_counter
   import gts_pkg::*;
#(
   parameter int unsigned WIDTH = 12,
   parameter int unsigned IMPL  = GTS_CNT_SHADOW
) (
   input  logic             clk,
   input  logic             rst,
   output logic [WIDTH-1:0] gray_o,
   output logic [WIDTH-1:0] gray_nxt_o
);

   localparam logic [WIDTH-1:0] TOP_GRAY = {1'b1, {(WIDTH-1){1'b0}}};

   function automatic logic [WIDTH-1:0] to_gray(input logic [WIDTH-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [WIDTH-1:0] to_bin(input logic [WIDTH-1:0] g);
      logic [WIDTH-1:0] b;
      b[WIDTH-1] = g[WIDTH-1];
      for (int i = int'(WIDTH) - 2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

   logic [WIDTH-1:0] gray_q;

   if (IMPL == GTS_CNT_SHADOW) begin : g_shadow
      logic [WIDTH-1:0] bin_q;
      logic [WIDTH-1:0] bin_inc;

      assign bin_inc    = bin_q + 1'b1;
      assign gray_nxt_o = to_gray(bin_inc);

      always_ff @(posedge clk) begin
         if (rst) begin
            bin_q  <= '0;
            gray_q <= '0;
         end else begin
            bin_q  <= bin_inc;
            gray_q <= to_gray(bin_inc);
         end
      end
   end else begin : g_decode
      logic [WIDTH-1:0] bin_now;

      assign bin_now    = to_bin(gray_q);
      assign gray_nxt_o = to_gray(bin_now + 1'b1);

      always_ff @(posedge clk) begin
         if (rst) begin
            gray_q <= '0;
         end else begin
            gray_q <= gray_nxt_o;
         end
      end
   end

   assign gray_o = gray_q;

   if (IMPL > GTS_CNT_DECODE) begin : g_bad_impl
      $error("gts_gray_counter: IMPL must be 0 or 1");
   end

   // R1: one bit changes between consecutive counter values
   assert_one_bit_step_R1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> $countones(gray_q ^ $past(gray_q)) == 1);

   // R2: counter is zero in the cycle after a reset edge
   assert_reset_zero_R2: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> gray_q == '0);

   // R9: the only way back to zero outside reset is from the top code
   assert_wrap_from_top_R9: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && gray_q == '0) |-> $past(gray_q) == TOP_GRAY);

endmodule

// File: rtl/gts_chan_capture.sv
module gts_chan_capture
   import gts_pkg::*;
#(
   parameter int unsigned COARSE_W = 12,
   parameter int unsigned FINE_W   = 8,
   localparam int unsigned STAMP_W = COARSE_W + FINE_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                peak_i,
   input  logic                ext_stop_i,
   input  stop_src_e           stop_src_i,
   input  logic [COARSE_W-1:0] coarse_nxt_i,
   input  logic [FINE_W-1:0]   fine_i,
   output logic [STAMP_W-1:0]  stamp_o,
   output logic                valid_o
);

   logic               armed_q;
   logic               stop_hit;
   logic               valid_q;
   logic [STAMP_W-1:0] stamp_q;

   always_comb begin
      unique case (stop_src_i)
         STOP_ON_EXT:  stop_hit = armed_q & ext_stop_i;
         default:      stop_hit = armed_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
         valid_q <= 1'b0;
         stamp_q <= '0;
      end else begin
         armed_q <= (armed_q & ~stop_hit) | peak_i;
         valid_q <= stop_hit;
         if (stop_hit) begin
            stamp_q <= {coarse_nxt_i, fine_i};
         end
      end
   end

   assign stamp_o = stamp_q;
   assign valid_o = valid_q;

   // R2: nothing armed or valid right after a reset edge
   assert_reset_idle_R2: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!armed_q && !valid_q && stamp_q == '0));

   // R3: a peak always leaves the channel armed
   assert_peak_arms_R3: assert property (@(posedge clk) disable iff (rst)
      peak_i |=> armed_q);

   // R4: tick mode captures an armed channel on the next edge
   assert_tick_capture_R4: assert property (@(posedge clk) disable iff (rst)
      (armed_q && stop_src_i == STOP_ON_TICK) |=> valid_o);

   // R5: external mode captures when the stop arrives
   assert_ext_capture_R5: assert property (@(posedge clk) disable iff (rst)
      (armed_q && stop_src_i == STOP_ON_EXT && ext_stop_i) |=> valid_o);

   // R6: no capture without a prior arm
   assert_no_unarmed_capture_R6: assert property (@(posedge clk) disable iff (rst)
      !armed_q |=> !valid_o);

   // R6: external mode without a stop keeps waiting
   assert_ext_waits_R6: assert property (@(posedge clk) disable iff (rst)
      (stop_src_i == STOP_ON_EXT && !ext_stop_i) |=> !valid_o);

   // R8: stamp holds when no capture happened
   assert_stamp_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!valid_o && !$past(rst)) |-> $stable(stamp_o));

endmodule

// File: rtl/gray_stamp_latch.sv
module gray_stamp_latch
   import gts_pkg::*;
#(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned COARSE_W = 12,
   parameter int unsigned FINE_W   = 8,
   parameter int unsigned CNT_IMPL = GTS_CNT_SHADOW,
   localparam int unsigned STAMP_W = COARSE_W + FINE_W
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [NUM_CH-1:0]         peak_i,
   input  logic                      ext_stop_i,
   input  logic                      stop_sel_i,
   input  logic [NUM_CH*FINE_W-1:0]  fine_i,
   output logic [NUM_CH*STAMP_W-1:0] stamp_o,
   output logic [NUM_CH-1:0]         valid_o
);

   if (COARSE_W < GTS_MIN_COARSE || COARSE_W > GTS_MAX_COARSE) begin : g_bad_coarse
      $error("gray_stamp_latch: COARSE_W out of range");
   end
   if (FINE_W < 1) begin : g_bad_fine
      $error("gray_stamp_latch: FINE_W must be at least 1");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("gray_stamp_latch: NUM_CH must be at least 1");
   end

   logic [COARSE_W-1:0] gray_cur;
   logic [COARSE_W-1:0] gray_nxt;
   stop_src_e           stop_src;

   assign stop_src = stop_src_e'(stop_sel_i);

   gts_gray_counter #(
      .WIDTH (COARSE_W),
      .IMPL  (CNT_IMPL)
   ) i_counter (
      .clk        (clk),
      .rst        (rst),
      .gray_o     (gray_cur),
      .gray_nxt_o (gray_nxt)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      gts_chan_capture #(
         .COARSE_W (COARSE_W),
         .FINE_W   (FINE_W)
      ) i_capture (
         .clk          (clk),
         .rst          (rst),
         .peak_i       (peak_i[c]),
         .ext_stop_i   (ext_stop_i),
         .stop_src_i   (stop_src),
         .coarse_nxt_i (gray_nxt),
         .fine_i       (fine_i[c*FINE_W +: FINE_W]),
         .stamp_o      (stamp_o[c*STAMP_W +: STAMP_W]),
         .valid_o      (valid_o[c])
      );

      // R4, R7: a capture holds the counter value reached on its own edge
      assert_coarse_matches_R7: assert property (@(posedge clk) disable iff (rst)
         valid_o[c] |-> stamp_o[c*STAMP_W + FINE_W +: COARSE_W] == gray_cur);
   end

endmodule

// File: tb/test_gray_stamp_latch.sv
`timescale 1ns/1ps
module test_gray_stamp_latch;

   localparam int NCH = 4;
   localparam int CW  = 12;
   localparam int FW  = 8;
   localparam int SW  = CW + FW;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NCH-1:0]    peak = '0;
   logic              ext_stop = 1'b0;
   logic              stop_sel = 1'b0;
   logic [NCH*FW-1:0] fine = '0;
   logic [NCH*SW-1:0] stamp;
   logic [NCH-1:0]    valid;

   int total = 0;
   int bad   = 0;
   bit mon_on = 1'b0;

   always #2.5 clk = ~clk;

   gray_stamp_latch i_gray_stamp_latch (
      .clk        (clk),
      .rst        (rst),
      .peak_i     (peak),
      .ext_stop_i (ext_stop),
      .stop_sel_i (stop_sel),
      .fine_i     (fine),
      .stamp_o    (stamp),
      .valid_o    (valid)
   );

   typedef struct {
      int            ch;
      logic [SW-1:0] val;
      string         req;
   } exp_t;

   exp_t exp_q[$];

   // Reference model built from the requirements; pushes expected captures.
   logic [CW-1:0] m_cnt = '0;
   logic [NCH-1:0] m_arm = '0;
   logic [NCH-1:0] m_rearm = '0;
   logic [SW-1:0] m_stamp [NCH];

   initial for (int c = 0; c < NCH; c++) m_stamp[c] = '0;

   always @(posedge clk) begin
      if (rst) begin
         m_cnt   = '0;
         m_arm   = '0;
         m_rearm = '0;
         for (int c = 0; c < NCH; c++) m_stamp[c] = '0;
      end else begin
         m_cnt = m_cnt + 1'b1;
         for (int c = 0; c < NCH; c++) begin
            logic cap;
            exp_t e;
            cap = m_arm[c] & (stop_sel ? ext_stop : 1'b1);
            if (cap) begin
               e.ch  = c;
               e.val = {m_cnt ^ (m_cnt >> 1), fine[c*FW +: FW]};
               if (m_cnt == '0)      e.req = "R9";
               else if (m_rearm[c])  e.req = "R10";
               else if (stop_sel)    e.req = "R5 R7";
               else                  e.req = "R3 R4 R7";
               exp_q.push_back(e);
               m_stamp[c] = e.val;
            end
            m_rearm[c] = cap & peak[c];
            m_arm[c]   = (m_arm[c] & ~cap) | peak[c];
         end
      end
   end

   // Monitor: compares design output with the scoreboard at each falling edge.
   logic [NCH-1:0] prev_valid = '0;
   logic [CW-1:0]  prev_coarse [NCH];

   always @(negedge clk) begin
      if (mon_on) begin
         for (int c = 0; c < NCH; c++) begin
            logic [SW-1:0] got;
            got = stamp[c*SW +: SW];
            if (valid[c]) begin
               total++;
               if (exp_q.size() == 0) begin
                  bad++;
                  $display("FAIL R6 ch%0d unexpected capture: actual=%h expected=none", c, got);
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  if (e.ch != c || got !== e.val) begin
                     bad++;
                     $display("FAIL %s ch%0d stamp: actual=%h expected=%h (ch%0d)",
                              e.req, c, got, e.val, e.ch);
                  end
               end
               if (prev_valid[c]) begin
                  total++;
                  if ($countones(got[SW-1:FW] ^ prev_coarse[c]) != 1) begin
                     bad++;
                     $display("FAIL R1 ch%0d step: actual=%h expected one-bit change from %h",
                              c, got[SW-1:FW], prev_coarse[c]);
                  end
               end
               prev_coarse[c] = got[SW-1:FW];
            end else begin
               total++;
               if (got !== m_stamp[c]) begin
                  bad++;
                  $display("FAIL R8 ch%0d hold: actual=%h expected=%h", c, got, m_stamp[c]);
               end
            end
         end
         prev_valid = valid;
         if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL %s missing capture: actual=none expected=%h (ch%0d)",
                     exp_q[0].req, exp_q[0].val, exp_q[0].ch);
            exp_q.delete();
         end
      end
   end

   task automatic drive(input logic [NCH-1:0] pk, input logic ex, input logic sel);
      @(negedge clk);
      peak     = pk;
      ext_stop = ex;
      stop_sel = sel;
      for (int c = 0; c < NCH; c++) fine[c*FW +: FW] = FW'($urandom);
   endtask

   task automatic check_reset_state();
      for (int c = 0; c < NCH; c++) begin
         total++;
         if (valid[c] !== 1'b0 || stamp[c*SW +: SW] !== '0) begin
            bad++;
            $display("FAIL R2 ch%0d reset: actual=%b/%h expected=0/0",
                     c, valid[c], stamp[c*SW +: SW]);
         end
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      mon_on = 1'b1;
      check_reset_state();
      rst = 1'b0;

      // R3 R4: tick mode, sparse random peaks
      for (int i = 0; i < 300; i++) drive(NCH'($urandom & $urandom), 1'($urandom), 1'b0);

      // R10 R1: channel 0 strobed every cycle, back-to-back captures
      for (int i = 0; i < 12; i++) drive(4'b0001, 1'b0, 1'b0);
      drive('0, 1'b0, 1'b0);
      drive('0, 1'b0, 1'b0);

      // R5 R6: external mode, repeated peaks on armed channels, rare stops
      for (int i = 0; i < 400; i++)
         drive(NCH'($urandom & $urandom), ($urandom % 8) == 0, 1'b1);

      // R6: stop while unarmed, peak with stop on an unarmed channel
      drive('0, 1'b0, 1'b1);
      for (int i = 0; i < 4; i++) drive('0, 1'b1, 1'b1);
      drive(4'b0010, 1'b1, 1'b1);
      drive(4'b0010, 1'b0, 1'b1);
      drive('0, 1'b0, 1'b1);
      drive('0, 1'b1, 1'b1);
      drive('0, 1'b0, 1'b1);

      // R4: armed in external mode, then switched to tick mode
      drive(4'b1100, 1'b0, 1'b1);
      drive('0, 1'b0, 1'b1);
      drive('0, 1'b0, 1'b0);
      drive('0, 1'b0, 1'b0);

      // R9: approach the wrap and capture across it
      while (m_cnt < 12'd4088) drive('0, 1'b0, 1'b0);
      for (int i = 0; i < 16; i++) drive(4'b1111, 1'b0, 1'b0);
      drive('0, 1'b0, 1'b0);

      // R2: reset while channels are armed, then stops with no peaks
      drive(4'b1111, 1'b0, 1'b1);
      @(negedge clk);
      rst  = 1'b1;
      peak = '0;
      @(negedge clk);
      @(negedge clk);
      check_reset_state();
      rst = 1'b0;
      for (int i = 0; i < 6; i++) drive('0, 1'b1, 1'b1);
      for (int i = 0; i < 6; i++) drive('0, 1'b0, 1'b0);

      repeat (3) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule